// File: doc/BRIEF.md
# Enclosure LED Serializer

This block holds the LED state of every drive port of a storage controller and sends it to an enclosure LED controller over three wires: a clock, a load strobe and a data line. Each port has three indications: activity, locate and fault. A port does not write its bits at a fixed place. A slot map assigns each port a slot, and the port's three bits sit at that slot's position in the pattern.

A caller presents an update with the port number and a 32-bit state word. When the serializer is idle it takes the update, rewrites the three bits of that port's slot and starts a frame at once. The frame has four parts, in this order:
- a programmable number of leading idle clocks;
- one clock during which load is high;
- the whole pattern, lowest bit first, one bit per clock;
- a programmable number of trailing idle clocks.

Every serial clock is high for one half-period and then low for one half-period. The length of a half-period, in core clock cycles, is set by a parameter. While a frame is in progress, busy is high and new updates are refused.

Top module: `encl_led_serializer`

## Requirements
- R1: After reset the pattern is all zeros, busy is low, and the clock, load and data outputs are all low.
- R2: The bits of port p sit at positions 3*s+0, 3*s+1 and 3*s+2 of the pattern, where s is the slot that slot_map_i gives for port p. Activity is k=0, locate is k=1 and fault is k=2.
- R3: Activity is set when state bit 20 or state bit 21 is set. It is cleared when both of these bits are clear.
- R4: Locate follows state bit 19 and fault follows state bit 22, each set or cleared by the update. No other state bit affects the pattern.
- R5: Each serial clock is high for HALF_DIV core cycles and then low for HALF_DIV core cycles. The serial clock stays low while idle.
- R6: A frame sends pre_clks_i idle clocks, then one clock with load high, then 3*N_PORTS data clocks, then post_clks_i idle clocks. Busy rises in the cycle after the update is accepted and stays high for exactly (pre+1+3*N_PORTS+post)*2*HALF_DIV cycles.
- R7: The data line changes only at the start of the high half of a clock and holds its value for the whole clock. It is low outside the data clocks.
- R8: An update presented while busy is high is ignored: the pattern does not change and no new frame starts.
- R9: When pre_clks_i and post_clks_i are both zero, the load clock is the first clock of the frame and the last data clock is the last one.
- R10: An update changes only the three bits of its own slot. All other bits keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | An update is presented |
| upd_port_i | input | PORT_W | Port that the update is for |
| upd_state_i | input | 32 | LED state word; bits 22..19 are used |
| slot_map_i | input | N_PORTS*SLOT_W | Slot of each port; port p uses field p |
| pre_clks_i | input | CNT_W | Number of leading idle clocks, sampled when an update is accepted |
| post_clks_i | input | CNT_W | Number of trailing idle clocks, sampled when an update is accepted |
| busy_o | output | 1 | A frame is in progress |
| sclk_o | output | 1 | Serial clock |
| sload_o | output | 1 | Load strobe |
| sdata_o | output | 1 | Serial data |

## Verification
Busy is due one core cycle after the edge that accepts an update. From then on, each frame position j maps to a fixed output value. The serial clock position is j mod 2*HALF_DIV, and the clock index is j / (2*HALF_DIV). From these two numbers the bench knows the expected serial clock, the load strobe and which data bit should be present. It also knows where busy must fall.

The bench numbers the falling edges from the first one after the accepting edge and compares every output at each of them. It reads each data bit in the first sample of its clock and requires that value in every later sample of the same clock. It rebuilds the pattern from the data line and compares it with a model that the bench keeps on its own. Refused updates are injected in the middle of a frame. The effect of a refused update is judged from the data of the next frame.

// File: rtl/encl_led_pkg.sv
package encl_led_pkg;

  localparam int LED_ACT = 0;
  localparam int LED_LOC = 1;
  localparam int LED_FLT = 2;
  localparam int LEDS_PER_PORT = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_LOAD,
    PH_DATA,
    PH_POST
  } phase_e;

  // State word to three indication bits, indexed by LED_*.
  function automatic logic [2:0] decode_leds(input logic [31:0] st);
    logic [2:0] b;
    b[LED_ACT] = st[20] | st[21];
    b[LED_LOC] = st[19];
    b[LED_FLT] = st[22];
    return b;
  endfunction

endpackage

// File: rtl/encl_led_pattern.sv
module encl_led_pattern #(
  parameter int N_PORTS = 4,
  parameter int SLOT_W  = 2,
  parameter int PORT_W  = 2,
  parameter int PAT_W   = 3 * N_PORTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_i,
  input  logic [PORT_W-1:0]         port_i,
  input  logic [31:0]               state_i,
  input  logic [N_PORTS*SLOT_W-1:0] slot_map_i,
  output logic [PAT_W-1:0]          pat_next_o,
  output logic [PAT_W-1:0]          pat_q_o
);
  import encl_led_pkg::*;

  // Write three indication bits at slot position; out-of-range slots are dropped.
  function automatic logic [PAT_W-1:0] merge_leds(input logic [PAT_W-1:0] pat,
                                                  input logic [SLOT_W-1:0] slot,
                                                  input logic [2:0] leds);
    logic [PAT_W-1:0] res;
    res = pat;
    for (int k = 0; k < LEDS_PER_PORT; k++) begin
      if (int'(slot) * LEDS_PER_PORT + k < PAT_W)
        res[int'(slot) * LEDS_PER_PORT + k] = leds[k];
    end
    return res;
  endfunction

  logic [SLOT_W-1:0] slot_sel;
  logic              port_ok;

  always_comb begin
    slot_sel = '0;
    port_ok  = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (port_i == PORT_W'(p)) begin
        slot_sel = slot_map_i[p*SLOT_W +: SLOT_W];
        port_ok  = 1'b1;
      end
    end
  end

  assign pat_next_o = port_ok ? merge_leds(pat_q_o, slot_sel, decode_leds(state_i)) : pat_q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pat_q_o <= '0;
    else if (upd_i) pat_q_o <= pat_next_o;
  end

endmodule

// File: rtl/encl_led_halfclk.sv
module encl_led_halfclk #(
  parameter int HALF_DIV = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic low_o,
  output logic cyc_start_o,
  output logic cyc_end_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             div_last;

  assign div_last    = (div_q == DIV_W'(HALF_DIV - 1));
  assign cyc_start_o = run_i && !low_o && (div_q == '0);
  assign cyc_end_o   = run_i && low_o && div_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      low_o <= 1'b0;
    end else if (start_i) begin
      div_q <= '0;
      low_o <= 1'b0;
    end else if (run_i) begin
      if (div_last) begin
        div_q <= '0;
        low_o <= ~low_o;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/encl_led_framer.sv
module encl_led_framer #(
  parameter int N_BITS = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  pre_i,
  input  logic [CNT_W-1:0]  post_i,
  input  logic [N_BITS-1:0] pat_i,
  input  logic              cyc_start_i,
  input  logic              cyc_end_i,
  output logic              busy_o,
  output logic              sload_o,
  output logic              sdata_o
);
  import encl_led_pkg::*;

  localparam int IDX_W = $clog2(N_BITS + 1);
  localparam int CW    = (CNT_W > IDX_W) ? CNT_W : IDX_W;

  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_inc;
  logic [CNT_W-1:0]  pre_q;
  logic [CNT_W-1:0]  post_q;
  logic [N_BITS-1:0] shreg_q;

  assign cnt_inc = cnt_q + 1'b1;
  assign busy_o  = (phase_q != PH_IDLE);
  assign sload_o = (phase_q == PH_LOAD);
  assign sdata_o = (phase_q == PH_DATA) && shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      phase_q <= (pre_i == '0) ? PH_LOAD : PH_PRE;
      cnt_q   <= '0;
      pre_q   <= pre_i;
      post_q  <= post_i;
      shreg_q <= pat_i;
    end else if (cyc_end_i) begin
      case (phase_q)
        PH_PRE: begin
          if (cnt_inc == CW'(pre_q)) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_LOAD: begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end
        PH_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (cnt_inc == CW'(N_BITS)) begin
            phase_q <= (post_q == '0) ? PH_IDLE : PH_POST;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_POST: begin
          if (cnt_inc == CW'(post_q)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_LOAD_AT_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload_o) |-> cyc_start_i); // R6
  AST_DATA_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cyc_start_i) |-> $stable(sdata_o)); // R7

endmodule

// File: rtl/encl_led_serializer.sv
module encl_led_serializer #(
  parameter int N_PORTS  = 4,
  parameter int SLOT_W   = 2,
  parameter int CNT_W    = 4,
  parameter int HALF_DIV = 6250,
  parameter int PORT_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_valid_i,
  input  logic [PORT_W-1:0]         upd_port_i,
  input  logic [31:0]               upd_state_i,
  input  logic [N_PORTS*SLOT_W-1:0] slot_map_i,
  input  logic [CNT_W-1:0]          pre_clks_i,
  input  logic [CNT_W-1:0]          post_clks_i,
  output logic                      busy_o,
  output logic                      sclk_o,
  output logic                      sload_o,
  output logic                      sdata_o
);
  localparam int PAT_W = 3 * N_PORTS;

  logic             accept;
  logic             low_half;
  logic             cyc_start;
  logic             cyc_end;
  logic [PAT_W-1:0] pat_next;
  logic [PAT_W-1:0] pat_q;

  assign accept = upd_valid_i && !busy_o;
  assign sclk_o = busy_o && !low_half;

  encl_led_pattern #(
    .N_PORTS(N_PORTS), .SLOT_W(SLOT_W), .PORT_W(PORT_W), .PAT_W(PAT_W)
  ) u_pattern (
    .clk(clk), .rst_n(rst_n), .upd_i(accept), .port_i(upd_port_i),
    .state_i(upd_state_i), .slot_map_i(slot_map_i),
    .pat_next_o(pat_next), .pat_q_o(pat_q)
  );

  encl_led_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .run_i(busy_o),
    .low_o(low_half), .cyc_start_o(cyc_start), .cyc_end_o(cyc_end)
  );

  encl_led_framer #(.N_BITS(PAT_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .start_i(accept),
    .pre_i(pre_clks_i), .post_i(post_clks_i), .pat_i(pat_next),
    .cyc_start_i(cyc_start), .cyc_end_i(cyc_end),
    .busy_o(busy_o), .sload_o(sload_o), .sdata_o(sdata_o)
  );

  AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && !busy_o) |=> busy_o); // R6
  AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && busy_o) |=> $stable(pat_q)); // R8

endmodule

// File: tb/encl_led_serializer_bench.sv
module encl_led_serializer_bench;
  localparam int N  = 4;
  localparam int SW = 2;
  localparam int PW = 2;
  localparam int CW = 4;
  localparam int HD = 3;
  localparam int NB = 3 * N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            upd_valid;
  logic [PW-1:0]   upd_port;
  logic [31:0]     upd_state;
  logic [N*SW-1:0] slot_map;
  logic [CW-1:0]   pre_clks, post_clks;
  logic            busy, sclk, sload, sdata;

  int checks = 0;
  int errors = 0;
  int slot_of [N] = '{2, 0, 3, 1};
  logic [NB-1:0] exp_pat = '0;

  encl_led_serializer #(
    .N_PORTS(N), .SLOT_W(SW), .CNT_W(CW), .HALF_DIV(HD), .PORT_W(PW)
  ) u_encl_led_serializer (
    .clk(clk), .rst_n(rst_n), .upd_valid_i(upd_valid), .upd_port_i(upd_port),
    .upd_state_i(upd_state), .slot_map_i(slot_map),
    .pre_clks_i(pre_clks), .post_clks_i(post_clks),
    .busy_o(busy), .sclk_o(sclk), .sload_o(sload), .sdata_o(sdata)
  );

  function automatic logic [NB-1:0] model_update(input logic [NB-1:0] pat, input int port,
                                                 input logic [31:0] st);
    logic [NB-1:0] leds;
    logic [NB-1:0] mask;
    int base;
    base = 3 * slot_of[port];
    leds = NB'({st[22], st[19], (st[21] | st[20])}) << base;
    mask = NB'(3'b111) << base;
    return (pat & ~mask) | leds;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One frame; inj_at >= 0 presents a refused update at that sample.
  task automatic run_frame(input int port, input logic [31:0] st, input int pre,
                           input int post, input int inj_at, input string tag);
    int len;
    bit clk_ok, load_ok, busy_ok, hold_ok, inj_busy;
    logic [NB-1:0] got;
    len = (pre + 1 + NB + post) * 2 * HD;
    clk_ok = 1; load_ok = 1; busy_ok = 1; hold_ok = 1; inj_busy = 1; got = '0;
    @(negedge clk);
    upd_valid = 1'b1; upd_port = PW'(port); upd_state = st;
    pre_clks = CW'(pre); post_clks = CW'(post);
    exp_pat = model_update(exp_pat, port, st);
    @(negedge clk);
    for (int j = 0; j < len + 3; j++) begin
      int b, w;
      b = j / (2 * HD);
      w = j % (2 * HD);
      upd_valid = (j == inj_at);
      if (j == inj_at) begin
        upd_port  = PW'($urandom_range(N - 1));
        upd_state = ~st;
        pre_clks  = '0;
        post_clks = '0;
        if (busy !== 1'b1) inj_busy = 0;
      end
      if (busy !== (j < len)) busy_ok = 0;
      if (j < len) begin
        if (sclk !== (w < HD)) clk_ok = 0;
        if (sload !== (b == pre)) load_ok = 0;
        if (b > pre && b <= pre + NB) begin
          if (w == 0) got[b - pre - 1] = sdata;
          else if (sdata !== got[b - pre - 1]) hold_ok = 0;
        end else if (sdata !== 1'b0) hold_ok = 0;
      end else if (sclk !== 1'b0 || sload !== 1'b0 || sdata !== 1'b0) clk_ok = 0;
      @(negedge clk);
    end
    upd_valid = 1'b0;
    chk(clk_ok, "R5", "serial clock shape", int'(clk_ok), 1);
    chk(load_ok && busy_ok, "R6", "load position and busy length",
        int'(load_ok && busy_ok), 1);
    chk(hold_ok, "R7", "data held for the whole clock", int'(hold_ok), 1);
    chk(got == exp_pat, tag, "serialized pattern", int'(got), int'(exp_pat));
    if (inj_at >= 0) chk(inj_busy, "R8", "busy while update refused", int'(inj_busy), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected frame completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; upd_valid = 1'b0; upd_port = '0; upd_state = '0;
    pre_clks = '0; post_clks = '0;
    for (int p = 0; p < N; p++) slot_map[p*SW +: SW] = SW'(slot_of[p]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset, serial clock low while idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({busy, sclk, sload, sdata} == 4'b0, "R1", "idle outputs after reset",
          int'({busy, sclk, sload, sdata}), 0);
    end
    // R1 / R9: zero pattern, no leading or trailing clocks
    run_frame(0, 32'h0, 0, 0, -1, "R1/R9");
    // R3: either activity bit sets activity
    run_frame(1, 32'h0010_0000, 0, 0, -1, "R3");
    run_frame(1, 32'h0, 1, 0, -1, "R3");
    run_frame(1, 32'h0020_0000, 0, 2, -1, "R3");
    // R4: locate, fault, other bits without effect
    run_frame(2, 32'h0008_0000, 2, 1, -1, "R4");
    run_frame(2, 32'h0040_0000, 0, 0, -1, "R4");
    run_frame(3, 32'hFF87_FFFF, 3, 3, -1, "R4");
    // R8: refused update in the middle of a frame, judged by the next frame
    run_frame(0, 32'h0048_0000, 1, 1, 20, "R2");
    run_frame(3, 32'h0030_0000, 0, 0, 5, "R8");
    run_frame(1, 32'h0000_0000, 2, 0, -1, "R8");
    // R2 / R10: random updates, every pattern compared in full
    for (int n = 0; n < 30; n++) begin
      logic [31:0] st;
      int inj;
      st = $urandom();
      inj = ($urandom_range(3) == 0) ? int'($urandom_range(40)) : -1;
      run_frame(int'($urandom_range(N - 1)), st, int'($urandom_range(15)),
                int'($urandom_range(15)), inj, "R2/R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule